// File: doc/BRIEF.md
# Write-Protection Unlock Command Decoder

This block sits on the write side of a byte-wide nonvolatile memory. It monitors every bus write cycle (address and data) and picks out unlock command sequences. The short form is three bytes long. The long form is six bytes long and begins with the same two unlock bytes. From these sequences it authorises one page load, turns global write protection on or off, starts a whole-array erase, and moves in and out of an identification read mode. Writes that belong to no sequence are passed on as ordinary byte loads. When protection is on and no page has been authorised, such a write is refused, and the block shuts out further writes for a fixed lockout period.

The protection flag behaves as a nonvolatile bit. Only the power-on reset clears it, and a soft reset leaves it as it is. The decoder holds the page authorisation until the page-buffer controller signals that the page write has finished. The next page then needs the unlock sequence again. While identification mode is active, a read at offset 0 returns the manufacturer code and a read at offset 1 returns the device code. The page buffer and the array lie outside this block.

Top module: `sdp_cmd_decoder`

## Requirements
- R1: The sequence AA at 5555, then 55 at 2AAA, then A0 at 5555 (all hex) sets `page_auth` and sets `prot_flag`. From then on, every write pulses `byte_load` and is not decoded, until a `page_done` pulse clears `page_auth`.
- R2: The first two unlock bytes followed by 90 at 5555 set `id_mode`. The same two bytes followed by F0 at 5555 clear it.
- R3: While `id_mode` is 1, `id_data` is BF when `rd_sel` is 0 and DEV_CODE (default 08) when `rd_sel` is 1. While `id_mode` is 0, `id_data` is 00.
- R4: The six-byte sequence AA/5555, 55/2AAA, 80/5555, AA/5555, 55/2AAA, 20/5555 clears `prot_flag`.
- R5: The same six-byte prefix ending in 10 at 5555 pulses `erase_start`.
- R6: The same six-byte prefix ending in 60 at 5555 sets `id_mode`.
- R7: Only address bits 14:0 take part in the match. Bits 16:15 of `wr_addr` have no effect on decoding.
- R8: A byte that does not match the expected step returns the decoder to idle and is handled as an ordinary write. A byte that does match a step never pulses `byte_load`.
- R9: An ordinary write pulses `byte_load` when `prot_flag` is 0. When `prot_flag` is 1 and no page is authorised, the write gives no `byte_load` and raises `lockout` for exactly LOCK_CYCLES cycles. Every write made while `lockout` is 1 is ignored, including any unlock bytes.
- R10: `por_n` low clears all state, `prot_flag` included. `rst_n` low clears the sequence state, `page_auth`, `id_mode` and `lockout`, but keeps `prot_flag`.
- R11: `byte_load` and `erase_start` are registered. Each is high for exactly the one cycle after the clock edge that sampled the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; also clears the protection flag |
| rst_n | input | 1 | Soft reset, active low; keeps the protection flag |
| wr_en | input | 1 | One-cycle strobe marking a bus write |
| wr_addr | input | ADDR_W (17) | Write address |
| wr_data | input | 8 | Write data |
| page_done | input | 1 | Pulse from the page-buffer controller when the page write has finished |
| rd_sel | input | 1 | Lowest read address bit, selects the identification byte |
| byte_load | output | 1 | Pulse: the write is accepted as a page-buffer byte load |
| erase_start | output | 1 | Pulse: start a whole-array erase |
| page_auth | output | 1 | One page load is authorised |
| prot_flag | output | 1 | Global write protection is on |
| id_mode | output | 1 | Identification read mode is active |
| lockout | output | 1 | Writes are being refused after a blocked write |
| id_data | output | 8 | Identification byte for the current read |

## Verification
The assertions assume that `wr_en` is high for at most one cycle per bus write, and that `page_done` comes only while a page is authorised and never in the same cycle as a write. The bench drives every write as a single-cycle strobe and issues `page_done` only on idle cycles after an authorised page load. It sweeps the unlock prefix with every combination of the ignored upper address bits, corrupts each sequence step in turn, and counts the length of the lockout window cycle by cycle.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

  localparam int CMP_W = 15;

  localparam logic [CMP_W-1:0] KEY_ADDR_A = 15'h5555;
  localparam logic [CMP_W-1:0] KEY_ADDR_B = 15'h2AAA;

  localparam logic [7:0] KEY_DATA_A  = 8'hAA;
  localparam logic [7:0] KEY_DATA_B  = 8'h55;
  localparam logic [7:0] OP_PAGE     = 8'hA0;
  localparam logic [7:0] OP_ID_ENTER = 8'h90;
  localparam logic [7:0] OP_ID_LEAVE = 8'hF0;
  localparam logic [7:0] OP_EXTEND   = 8'h80;
  localparam logic [7:0] OP_UNPROT   = 8'h20;
  localparam logic [7:0] OP_ERASE    = 8'h10;
  localparam logic [7:0] OP_ID_ALT   = 8'h60;
  localparam logic [7:0] MAKER_CODE  = 8'hBF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_K1, ST_K2, ST_X0, ST_X1, ST_X2
  } seq_state_t;

  typedef enum logic [2:0] {
    EV_NONE, EV_PAGE, EV_ID_IN, EV_ID_OUT, EV_UNPROT, EV_ERASE
  } seq_event_t;

  // Match only the low address bits against an unlock address.
  function automatic logic addr_hit(input logic [CMP_W-1:0] a,
                                    input logic [CMP_W-1:0] pat);
    return a == pat;
  endfunction

  // Identification byte for the selected offset.
  function automatic logic [7:0] id_byte(input logic active, input logic sel,
                                         input logic [7:0] dev);
    if (!active) return 8'h00;
    return sel ? dev : MAKER_CODE;
  endfunction

endpackage

// File: rtl/sdp_seq_fsm.sv
module sdp_seq_fsm
  import sdp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic [CMP_W-1:0] addr,
  input  logic [7:0]       data,
  output seq_event_t       evt,
  output logic             plain
);

  seq_state_t state, nxt;
  logic at_a, at_b;

  assign at_a = addr_hit(addr, KEY_ADDR_A);
  assign at_b = addr_hit(addr, KEY_ADDR_B);

  always_comb begin
    nxt   = state;
    evt   = EV_NONE;
    plain = 1'b0;
    if (step_en) begin
      nxt = ST_IDLE;
      unique case (state)
        ST_IDLE: if (at_a && data == KEY_DATA_A) nxt = ST_K1; else plain = 1'b1;
        ST_K1:   if (at_b && data == KEY_DATA_B) nxt = ST_K2; else plain = 1'b1;
        ST_K2: begin
          if (at_a && data == OP_PAGE)          evt = EV_PAGE;
          else if (at_a && data == OP_ID_ENTER) evt = EV_ID_IN;
          else if (at_a && data == OP_ID_LEAVE) evt = EV_ID_OUT;
          else if (at_a && data == OP_EXTEND)   nxt = ST_X0;
          else                                  plain = 1'b1;
        end
        ST_X0:   if (at_a && data == KEY_DATA_A) nxt = ST_X1; else plain = 1'b1;
        ST_X1:   if (at_b && data == KEY_DATA_B) nxt = ST_X2; else plain = 1'b1;
        ST_X2: begin
          if (at_a && data == OP_UNPROT)      evt = EV_UNPROT;
          else if (at_a && data == OP_ERASE)  evt = EV_ERASE;
          else if (at_a && data == OP_ID_ALT) evt = EV_ID_IN;
          else                                plain = 1'b1;
        end
        default: plain = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  // R8
  mismatch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    plain |=> state == ST_IDLE);

  // R8
  final_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != EV_NONE) |=> state == ST_IDLE);

  // R9
  hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(state));

endmodule

// File: rtl/sdp_lock_timer.sv
module sdp_lock_timer #(
  parameter int LOCK_CYCLES = 15000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(LOCK_CYCLES);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (start)     cnt <= LOAD_VAL;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // R9
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

endmodule

// File: rtl/sdp_id_resp.sv
module sdp_id_resp
  import sdp_pkg::*;
#(
  parameter logic [7:0] DEV_CODE = 8'h08
) (
  input  logic       active,
  input  logic       sel,
  output logic [7:0] data
);

  assign data = id_byte(active, sel, DEV_CODE);

endmodule

// File: rtl/sdp_cmd_decoder.sv
module sdp_cmd_decoder
  import sdp_pkg::*;
#(
  parameter int         ADDR_W      = 17,
  parameter int         LOCK_CYCLES = 15000,
  parameter logic [7:0] DEV_CODE    = 8'h08
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              page_done,
  input  logic              rd_sel,
  output logic              byte_load,
  output logic              erase_start,
  output logic              page_auth,
  output logic              prot_flag,
  output logic              id_mode,
  output logic              lockout,
  output logic [7:0]        id_data
);

  logic       sys_rst_n;
  logic       wr_live;
  logic       step_en;
  logic       plain;
  logic       load_now;
  logic       block_now;
  logic       unused_addr_hi;
  seq_event_t evt;

  assign sys_rst_n      = por_n & rst_n;
  assign unused_addr_hi = ^wr_addr[ADDR_W-1:CMP_W];

  // Writes refused while the lockout window runs.
  assign wr_live   = wr_en & ~lockout;
  assign step_en   = wr_live & ~page_auth;
  assign load_now  = wr_live & (page_auth | (plain & ~prot_flag));
  assign block_now = step_en & plain & prot_flag;

  sdp_seq_fsm u_seq (
    .clk     (clk),
    .rst_n   (sys_rst_n),
    .step_en (step_en),
    .addr    (wr_addr[CMP_W-1:0]),
    .data    (wr_data),
    .evt     (evt),
    .plain   (plain)
  );

  sdp_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk   (clk),
    .rst_n (sys_rst_n),
    .start (block_now),
    .busy  (lockout)
  );

  sdp_id_resp #(.DEV_CODE(DEV_CODE)) u_id (
    .active (id_mode),
    .sel    (rd_sel),
    .data   (id_data)
  );

  // Nonvolatile-style protection bit: power-on reset only.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                 prot_flag <= 1'b0;
    else if (evt == EV_PAGE)    prot_flag <= 1'b1;
    else if (evt == EV_UNPROT)  prot_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      page_auth   <= 1'b0;
      id_mode     <= 1'b0;
      byte_load   <= 1'b0;
      erase_start <= 1'b0;
    end else begin
      byte_load   <= load_now;
      erase_start <= (evt == EV_ERASE);
      if (evt == EV_PAGE)        page_auth <= 1'b1;
      else if (page_done)        page_auth <= 1'b0;
      if (evt == EV_ID_IN)       id_mode <= 1'b1;
      else if (evt == EV_ID_OUT) id_mode <= 1'b0;
    end
  end

  // R9
  load_not_locked_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    byte_load |-> !$past(lockout));

  // R9
  lock_needs_flag_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    $rose(lockout) |-> prot_flag);

  // R4
  flag_clear_by_write_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    $fell(prot_flag) |-> $past(wr_en));

  // R1
  auth_implies_flag_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    page_auth |-> prot_flag);

  // R11
  erase_single_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    erase_start |=> !erase_start);

  // R11
  load_from_write_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    byte_load |-> $past(wr_en));

endmodule

// File: tb/tb_sdp_cmd_decoder.sv
`timescale 1ns/1ps
module tb_sdp_cmd_decoder;

  localparam int LOCK = 12;
  localparam logic [7:0] DEV = 8'h08;

  logic        clk = 1'b0;
  logic        por_n = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, page_done = 1'b0, rd_sel = 1'b0;
  logic [16:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        byte_load, erase_start, page_auth, prot_flag, id_mode, lockout;
  logic [7:0]  id_data;

  int checks = 0, errors = 0;
  logic got_load, got_erase;

  always #10 clk = ~clk;

  sdp_cmd_decoder #(.ADDR_W(17), .LOCK_CYCLES(LOCK), .DEV_CODE(DEV)) dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .page_done(page_done), .rd_sel(rd_sel),
    .byte_load(byte_load), .erase_start(erase_start), .page_auth(page_auth),
    .prot_flag(prot_flag), .id_mode(id_mode), .lockout(lockout), .id_data(id_data)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %h exp %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [16:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    got_load = byte_load; got_erase = erase_start;
    wr_en = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk); #1;
  endtask

  task automatic done_page();
    @(negedge clk); page_done = 1'b1;
    @(posedge clk); #1; page_done = 1'b0;
  endtask

  task automatic pre2(input logic [1:0] hi);
    wr({hi, 15'h5555}, 8'hAA);
    chk("R8 key1 no load", {7'd0, got_load}, 8'h00);
    wr({hi, 15'h2AAA}, 8'h55);
    chk("R8 key2 no load", {7'd0, got_load}, 8'h00);
  endtask

  task automatic seq6(input logic [7:0] fin);
    pre2(2'b00);
    wr(17'h05555, 8'h80);
    pre2(2'b00);
    wr(17'h05555, fin);
  endtask

  task automatic wait_lock();
    while (lockout) idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); por_n = 1'b1; rst_n = 1'b1;
    idle();
    // R10 reset state
    chk("R10 reset prot_flag", {7'd0, prot_flag}, 8'h00);
    chk("R10 reset page_auth", {7'd0, page_auth}, 8'h00);
    chk("R10 reset id_mode",   {7'd0, id_mode},   8'h00);
    chk("R10 reset lockout",   {7'd0, lockout},   8'h00);
    chk("R3 id_data off",      id_data,           8'h00);

    // R9 unprotected ordinary writes load; R11 single-cycle pulse
    for (int i = 0; i < 6; i++) begin
      wr(17'(i * 4099 + 3), 8'(i * 37));
      chk("R9 plain load", {7'd0, got_load}, 8'h01);
      idle();
      chk("R11 load one cycle", {7'd0, byte_load}, 8'h00);
    end

    // R8 corrupt each step of the short prefix (unprotected)
    for (int s = 0; s < 3; s++) begin
      if (s > 0) begin wr(17'h05555, 8'hAA); chk("R8 ok step", {7'd0, got_load}, 8'h00); end
      if (s > 1) begin wr(17'h02AAA, 8'h55); chk("R8 ok step", {7'd0, got_load}, 8'h00); end
      wr(17'h01234, 8'h3C);
      chk("R8 mismatch loads", {7'd0, got_load}, 8'h01);
      chk("R8 no auth", {7'd0, page_auth}, 8'h00);
    end

    // R1 page write prefix, R7 over all upper address bits
    for (int h = 0; h < 4; h++) begin
      pre2(2'(h));
      wr({2'(h), 15'h5555}, 8'hA0);
      chk("R1 A0 no load", {7'd0, got_load}, 8'h00);
      chk("R7 auth upper bits", {7'd0, page_auth}, 8'h01);
      chk("R1 flag set", {7'd0, prot_flag}, 8'h01);
      for (int b = 0; b < 4; b++) begin
        wr(17'h00400 + 17'(b), 8'h5A + 8'(b));
        chk("R1 auth load", {7'd0, got_load}, 8'h01);
      end
      wr(17'h05555, 8'hAA);
      chk("R1 bypass decode", {7'd0, got_load}, 8'h01);
      done_page();
      chk("R1 auth dropped", {7'd0, page_auth}, 8'h00);
      chk("R1 flag kept", {7'd0, prot_flag}, 8'h01);
    end

    // R9 protected blocked write and lockout length; writes ignored
    wr(17'h00777, 8'h11);
    chk("R9 blocked no load", {7'd0, got_load}, 8'h00);
    begin
      int n = 0;
      if (lockout) n = 1;
      wr(17'h05555, 8'hAA); if (lockout) n++;
      chk("R9 locked no load", {7'd0, got_load}, 8'h00);
      wr(17'h02AAA, 8'h55); if (lockout) n++;
      wr(17'h05555, 8'hA0); if (lockout) n++;
      chk("R9 ignored prefix", {7'd0, page_auth}, 8'h00);
      while (lockout) begin idle(); if (lockout) n++; end
      chk("R9 lockout length", 8'(n), 8'(LOCK));
    end
    wr(17'h00777, 8'h11);
    chk("R9 still blocked", {7'd0, got_load}, 8'h00);
    chk("R9 relock", {7'd0, lockout}, 8'h01);
    wait_lock();

    // R8 mismatch at final six-byte step while protected -> blocked
    seq6(8'h77);
    chk("R8 six mismatch no load", {7'd0, got_load}, 8'h00);
    chk("R8 six mismatch locks", {7'd0, lockout}, 8'h01);
    wait_lock();

    // R2 / R3 identification
    pre2(2'b00);
    wr(17'h05555, 8'h90);
    chk("R2 id enter", {7'd0, id_mode}, 8'h01);
    for (int r = 0; r < 4; r++) begin
      rd_sel = r[0]; #1;
      chk("R3 id byte", id_data, r[0] ? DEV : 8'hBF);
    end
    pre2(2'b00);
    wr(17'h05555, 8'hF0);
    chk("R2 id exit", {7'd0, id_mode}, 8'h00);
    chk("R3 id off", id_data, 8'h00);

    // R6 long-form id entry
    seq6(8'h60);
    chk("R6 id enter", {7'd0, id_mode}, 8'h01);
    rd_sel = 1'b0; #1;
    chk("R6 id maker", id_data, 8'hBF);

    // R10 soft reset keeps flag, clears id
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    idle();
    chk("R10 soft keeps flag", {7'd0, prot_flag}, 8'h01);
    chk("R10 soft clears id", {7'd0, id_mode}, 8'h00);

    // R5 erase pulse
    seq6(8'h10);
    chk("R5 erase pulse", {7'd0, got_erase}, 8'h01);
    chk("R5 erase no load", {7'd0, got_load}, 8'h00);
    idle();
    chk("R11 erase one cycle", {7'd0, erase_start}, 8'h00);

    // R4 disable protection
    seq6(8'h20);
    chk("R4 flag cleared", {7'd0, prot_flag}, 8'h00);
    wr(17'h00100, 8'h42);
    chk("R4 plain load again", {7'd0, got_load}, 8'h01);

    // R10 power-on reset clears flag
    pre2(2'b00);
    wr(17'h05555, 8'hA0);
    chk("R1 flag set again", {7'd0, prot_flag}, 8'h01);
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    idle();
    chk("R10 por clears flag", {7'd0, prot_flag}, 8'h00);
    chk("R10 por clears auth", {7'd0, page_auth}, 8'h00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act hung exp done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule